// File: doc/BRIEF.md
# Exception-Return Frame Unwind Sequencer

This block carries out the return-from-exception step of a 32-bit core. When it is started, it reads a two-longword frame from the supervisor stack through a simple memory read port. The first longword holds a 4-bit frame format code in its upper bits and the saved status word in its lower half. The second longword holds the return address.

The sequencer checks the format code before it uses anything else in the frame. If the code is acceptable, it fetches the return address and hands back a restored status word, a new program counter and an adjusted stack pointer, marked by a one-cycle done pulse. If the code is not acceptable, it makes no further memory access. It then raises a one-cycle format-error request that carries the address of the return instruction and a fixed vector number, so that the core can take a fresh exception while the original frame stays as it was.

The core drives a start pulse together with the current stack pointer and the address of the return instruction. Memory answers each read with a ready strobe after any number of wait cycles.

Top module: `frame_unwind_seq`

## Requirements
- R1: After reset the block is idle: `rd_req_o`, `done_o` and `fmt_err_o` are low, and `sr_o`, `pc_o` and `sp_o` are zero.
- R2: One cycle after an accepted start, the block requests a read at the supplied stack pointer. While `rd_ready_i` is low, `rd_req_o` stays high and `rd_addr_o` does not change, for any number of wait cycles.
- R3: The format code is bits 31:28 of the first longword. A code outside 4..7 ends the operation. One cycle after the ready, `fmt_err_o` pulses for one cycle, with `err_pc_o` equal to the return-instruction address and `err_vec_o` equal to 14. No second read follows.
- R4: A rejected frame leaves `sr_o`, `pc_o` and `sp_o` at their previous values.
- R5: For an accepted frame, `sr_o` becomes bits 15:0 of the first longword.
- R6: After an accepted first longword, the second read is requested at the stack pointer plus 4.
- R7: One cycle after the second ready, `done_o` pulses for one cycle. At that point `pc_o` equals the second longword and `sp_o` equals stack pointer + 4 + format code.
- R8: A start pulse that arrives while an operation is in progress is ignored. The address in use and the results are unaffected.
- R9: Any first longword with bit 30 clear is rejected through the format-error path. This covers an old-style frame whose top word is a status register.
- R10: Each accepted start produces exactly one of `done_o` or `fmt_err_o`, and the two are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an exception return (ignored while busy) |
| sp_i | input | 32 | Current supervisor stack pointer |
| ret_pc_i | input | 32 | Address of the return instruction |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | 32 | Read address, held until ready |
| rd_data_i | input | 32 | Read data, valid with ready |
| rd_ready_i | input | 1 | Read completes this cycle |
| done_o | output | 1 | One-cycle pulse: results valid |
| sr_o | output | 16 | Restored status word |
| pc_o | output | 32 | Return address |
| sp_o | output | 32 | Adjusted stack pointer |
| fmt_err_o | output | 1 | One-cycle format-error exception request |
| err_pc_o | output | 32 | PC to stack for the format-error exception |
| err_vec_o | output | 8 | Vector number of the format-error exception |

## Verification
The hardest case to reach from the ports is a second start that lands in the middle of an operation. It must change neither the held read address nor the results. The driver stretches the first read with wait cycles, raises `start_i` with a different stack pointer during those cycles, and checks the address on every wait cycle as well as the final scoreboard entry. The format boundaries 3/4 and 7/8, an old-style frame with bit 30 clear, and an accepted frame that directly follows a rejected one are each driven with their own frame words.

// File: rtl/frame_unwind_pkg.sv
package frame_unwind_pkg;

    localparam int FU_AW         = 32;
    localparam int FU_SR_W       = 16;
    localparam int FU_FMT_W      = 4;
    localparam int FU_FMT_LSB    = 28;
    localparam int FU_FMT_MIN    = 4;
    localparam int FU_FMT_MAX    = 7;
    localparam int FU_WORD_BYTES = 4;
    localparam int FU_VEC_W      = 8;

    typedef enum logic [1:0] {
        FU_IDLE   = 2'd0,
        FU_GET_SR = 2'd1,
        FU_GET_PC = 2'd2
    } fu_state_e;

    typedef struct packed {
        fu_state_e            state;
        logic [FU_AW-1:0]     base;
        logic [FU_AW-1:0]     rpc;
        logic [FU_SR_W-1:0]   st_sr;
        logic [FU_AW-1:0]     st_sp;
        logic [FU_SR_W-1:0]   sr;
        logic [FU_AW-1:0]     pc;
        logic [FU_AW-1:0]     sp;
        logic                 done;
        logic                 err;
    } fu_regs_t;

endpackage

// File: rtl/fu_fmt_decode.sv
module fu_fmt_decode #(
    parameter int FMT_W   = 4,
    parameter int FMT_MIN = 4,
    parameter int FMT_MAX = 7
) (
    input  logic [FMT_W-1:0] fmt_i,
    output logic             fmt_ok_o
);
    localparam logic [FMT_W-1:0] LO = FMT_W'(FMT_MIN);
    localparam logic [FMT_W-1:0] HI = FMT_W'(FMT_MAX);

    always_comb begin
        fmt_ok_o = (fmt_i >= LO) && (fmt_i <= HI);
    end
endmodule

// File: rtl/fu_sp_adjust.sv
module fu_sp_adjust #(
    parameter int AW    = 32,
    parameter int FMT_W = 4,
    parameter int STEP  = 4
) (
    input  logic [AW-1:0]    base_i,
    input  logic [FMT_W-1:0] fmt_i,
    output logic [AW-1:0]    next_addr_o,
    output logic [AW-1:0]    new_sp_o
);
    always_comb begin
        next_addr_o = base_i + AW'(STEP);
        new_sp_o    = next_addr_o + {{(AW-FMT_W){1'b0}}, fmt_i};
    end
endmodule

// File: rtl/frame_unwind_seq.sv
module frame_unwind_seq
    import frame_unwind_pkg::*;
#(
    parameter int ERR_VECTOR = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [FU_AW-1:0]     sp_i,
    input  logic [FU_AW-1:0]     ret_pc_i,
    output logic                 rd_req_o,
    output logic [FU_AW-1:0]     rd_addr_o,
    input  logic [FU_AW-1:0]     rd_data_i,
    input  logic                 rd_ready_i,
    output logic                 done_o,
    output logic [FU_SR_W-1:0]   sr_o,
    output logic [FU_AW-1:0]     pc_o,
    output logic [FU_AW-1:0]     sp_o,
    output logic                 fmt_err_o,
    output logic [FU_AW-1:0]     err_pc_o,
    output logic [FU_VEC_W-1:0]  err_vec_o
);
    localparam logic [FU_FMT_W-1:0] FMT_LO = FU_FMT_W'(FU_FMT_MIN);
    localparam logic [FU_FMT_W-1:0] FMT_HI = FU_FMT_W'(FU_FMT_MAX);
    localparam logic [FU_AW-1:0]    SP_LO  = FU_AW'(FU_WORD_BYTES + FU_FMT_MIN);
    localparam logic [FU_AW-1:0]    SP_HI  = FU_AW'(FU_WORD_BYTES + FU_FMT_MAX);

    fu_regs_t q, d;

    logic [FU_FMT_W-1:0] fmt_w;
    logic                fmt_ok;
    logic [FU_AW-1:0]    next_addr;
    logic [FU_AW-1:0]    new_sp;

    assign fmt_w = rd_data_i[FU_FMT_LSB +: FU_FMT_W];

    fu_fmt_decode #(
        .FMT_W  (FU_FMT_W),
        .FMT_MIN(FU_FMT_MIN),
        .FMT_MAX(FU_FMT_MAX)
    ) u_fmt (
        .fmt_i   (fmt_w),
        .fmt_ok_o(fmt_ok)
    );

    fu_sp_adjust #(
        .AW   (FU_AW),
        .FMT_W(FU_FMT_W),
        .STEP (FU_WORD_BYTES)
    ) u_sp (
        .base_i     (q.base),
        .fmt_i      (fmt_w),
        .next_addr_o(next_addr),
        .new_sp_o   (new_sp)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.err  = 1'b0;
        case (q.state)
            FU_IDLE: begin
                if (start_i) begin
                    d.base  = sp_i;
                    d.rpc   = ret_pc_i;
                    d.state = FU_GET_SR;
                end
            end
            FU_GET_SR: begin
                if (rd_ready_i) begin
                    if (fmt_ok) begin
                        d.st_sr = rd_data_i[FU_SR_W-1:0];
                        d.st_sp = new_sp;
                        d.state = FU_GET_PC;
                    end else begin
                        d.err   = 1'b1;
                        d.state = FU_IDLE;
                    end
                end
            end
            FU_GET_PC: begin
                if (rd_ready_i) begin
                    d.pc    = rd_data_i;
                    d.sr    = q.st_sr;
                    d.sp    = q.st_sp;
                    d.done  = 1'b1;
                    d.state = FU_IDLE;
                end
            end
            default: d.state = FU_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        rd_req_o  = (q.state != FU_IDLE);
        rd_addr_o = (q.state == FU_GET_PC) ? next_addr : q.base;
        done_o    = q.done;
        sr_o      = q.sr;
        pc_o      = q.pc;
        sp_o      = q.sp;
        fmt_err_o = q.err;
        err_pc_o  = q.rpc;
        err_vec_o = FU_VEC_W'(ERR_VECTOR);
    end

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o && !rd_ready_i |=> rd_req_o && $stable(rd_addr_o)); // R2

    AST_ERR_ONLY_BAD_FMT: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_err_o |-> ($past(fmt_w) < FMT_LO || $past(fmt_w) > FMT_HI)); // R3

    AST_NO_READ_AFTER_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_err_o |-> !rd_req_o); // R3

    AST_KEEP_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_err_o |-> $stable(sr_o) && $stable(pc_o) && $stable(sp_o)); // R4

    AST_SECOND_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o && rd_ready_i && fmt_ok && (q.state == FU_GET_SR)
        |=> rd_req_o && (rd_addr_o == $past(rd_addr_o) + FU_AW'(FU_WORD_BYTES))); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7

    AST_SP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ((sp_o - q.base) >= SP_LO) && ((sp_o - q.base) <= SP_HI)); // R7

    AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o && !rd_ready_i && start_i |=> rd_req_o && $stable(rd_addr_o)); // R8

    AST_OLD_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o && rd_ready_i && (q.state == FU_GET_SR) && !rd_data_i[30] |=> fmt_err_o); // R9

    AST_DONE_XOR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && fmt_err_o)); // R10

endmodule

// File: tb/frame_unwind_seq_bench.sv
`timescale 1ns/1ps
module frame_unwind_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] sp_i = '0;
    logic [31:0] ret_pc_i = '0;
    logic        rd_req_o;
    logic [31:0] rd_addr_o;
    logic [31:0] rd_data_i = '0;
    logic        rd_ready_i = 1'b0;
    logic        done_o;
    logic [15:0] sr_o;
    logic [31:0] pc_o;
    logic [31:0] sp_o;
    logic        fmt_err_o;
    logic [31:0] err_pc_o;
    logic [7:0]  err_vec_o;

    always #4 clk = ~clk;

    frame_unwind_seq u_frame_unwind_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sp_i(sp_i), .ret_pc_i(ret_pc_i),
        .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
        .rd_ready_i(rd_ready_i), .done_o(done_o), .sr_o(sr_o), .pc_o(pc_o),
        .sp_o(sp_o), .fmt_err_o(fmt_err_o), .err_pc_o(err_pc_o), .err_vec_o(err_vec_o)
    );

    typedef struct {
        bit          is_err;
        logic [15:0] sr;
        logic [31:0] pc;
        logic [31:0] sp;
        logic [31:0] epc;
    } exp_t;

    exp_t        sbq[$];
    int          n_run  = 0;
    int          n_fail = 0;
    logic [15:0] m_sr = '0;
    logic [31:0] m_pc = '0;
    logic [31:0] m_sp = '0;
    bit          mon_on = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Monitor: pops one expected item per result pulse
    always @(negedge clk) begin
        if (mon_on && (done_o || fmt_err_o)) begin
            chk(!(done_o && fmt_err_o), "R10", "done and error together", {30'd0, done_o, fmt_err_o}, 32'd0);
            if (sbq.size() == 0) begin
                chk(1'b0, "R10", "unexpected result pulse", {30'd0, done_o, fmt_err_o}, 32'd0);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                if (e.is_err) begin
                    chk(fmt_err_o, "R3", "error pulse expected", {31'd0, fmt_err_o}, 32'd1);
                    chk(err_pc_o == e.epc, "R3", "err_pc", err_pc_o, e.epc);
                    chk(err_vec_o == 8'd14, "R3", "err_vec", {24'd0, err_vec_o}, 32'd14);
                end else begin
                    chk(done_o, "R7", "done pulse expected", {31'd0, done_o}, 32'd1);
                    chk(sr_o == e.sr, "R5", "sr", {16'd0, sr_o}, {16'd0, e.sr});
                    chk(pc_o == e.pc, "R7", "pc", pc_o, e.pc);
                    chk(sp_o == e.sp, "R7", "sp", sp_o, e.sp);
                end
            end
        end
    end

    // Driver: pushes expectation, then plays the memory side
    task automatic run_frame(input logic [31:0] sp, input logic [31:0] rpc,
                             input logic [31:0] w0, input logic [31:0] w1,
                             input int wait0, input int wait1, input bit poke);
        exp_t       e;
        logic [3:0] fmt;
        bit         ok;
        fmt      = w0[31:28];
        ok       = (fmt >= 4'd4) && (fmt <= 4'd7);
        e.is_err = !ok;
        e.sr     = w0[15:0];
        e.pc     = w1;
        e.sp     = sp + 32'd4 + {28'd0, fmt};
        e.epc    = rpc;
        sbq.push_back(e);

        @(negedge clk);
        start_i = 1'b1; sp_i = sp; ret_pc_i = rpc;
        @(negedge clk);
        start_i = 1'b0; sp_i = 32'hDEAD_0000; ret_pc_i = 32'hDEAD_0004;
        chk(rd_req_o && rd_addr_o == sp, "R2", "first read addr", rd_addr_o, sp);
        for (int i = 0; i < wait0; i++) begin
            if (poke && i == 0) begin
                start_i = 1'b1; sp_i = 32'h5555_0000; ret_pc_i = 32'h5555_0100;
            end
            @(negedge clk);
            start_i = 1'b0;
            chk(rd_req_o && rd_addr_o == sp, poke ? "R8" : "R2", "addr held in wait", rd_addr_o, sp);
        end
        rd_data_i = w0; rd_ready_i = 1'b1;
        @(negedge clk);
        rd_ready_i = 1'b0; rd_data_i = 32'hBAD0_BAD0;
        if (!ok) begin
            chk(!rd_req_o, "R3", "no second read", {31'd0, rd_req_o}, 32'd0);
            chk(sr_o == m_sr, "R4", "sr kept", {16'd0, sr_o}, {16'd0, m_sr});
            chk(pc_o == m_pc, "R4", "pc kept", pc_o, m_pc);
            chk(sp_o == m_sp, "R4", "sp kept", sp_o, m_sp);
            @(negedge clk);
            chk(!rd_req_o && !fmt_err_o, "R3", "idle after error", {30'd0, rd_req_o, fmt_err_o}, 32'd0);
        end else begin
            chk(rd_req_o && rd_addr_o == sp + 32'd4, "R6", "second read addr", rd_addr_o, sp + 32'd4);
            for (int i = 0; i < wait1; i++) begin
                @(negedge clk);
                chk(rd_req_o && rd_addr_o == sp + 32'd4, "R2", "addr held in wait", rd_addr_o, sp + 32'd4);
            end
            rd_data_i = w1; rd_ready_i = 1'b1;
            @(negedge clk);
            rd_ready_i = 1'b0; rd_data_i = 32'hBAD0_BAD0;
            chk(!rd_req_o, "R7", "idle at done", {31'd0, rd_req_o}, 32'd0);
            m_sr = e.sr; m_pc = e.pc; m_sp = e.sp;
            @(negedge clk);
            chk(!done_o, "R7", "done is one cycle", {31'd0, done_o}, 32'd0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!rd_req_o && !done_o && !fmt_err_o, "R1", "idle flags",
            {29'd0, rd_req_o, done_o, fmt_err_o}, 32'd0);
        chk(sr_o == 16'd0 && pc_o == 32'd0 && sp_o == 32'd0, "R1", "zero results", pc_o | sp_o, 32'd0);
        mon_on = 1'b1;

        // R5 R7: format 4, no waits
        run_frame(32'h0000_1000, 32'h0000_0400, 32'h4000_2704, 32'h0000_8000, 0, 0, 1'b0);
        // R2: format 7 with wait cycles on both reads
        run_frame(32'h0001_2000, 32'h0000_0410, 32'h7000_A5A5, 32'h1234_5678, 3, 2, 1'b0);
        // format 5 and 6
        run_frame(32'h0002_0010, 32'h0000_0420, 32'h5000_0001, 32'hCAFE_0000, 1, 0, 1'b0);
        run_frame(32'hFFFF_FFF0, 32'h0000_0430, 32'h6000_FFFF, 32'h0000_0002, 0, 4, 1'b0);
        // R9: old-style frame, status word on top, bit 30 clear
        run_frame(32'h0003_0000, 32'h0000_0440, 32'h2700_0100, 32'h1111_1111, 2, 0, 1'b0);
        // R3: boundaries 3 and 8, and 15
        run_frame(32'h0004_0000, 32'h0000_0450, 32'h3000_1234, 32'h2222_2222, 0, 0, 1'b0);
        run_frame(32'h0005_0000, 32'h0000_0460, 32'h8000_4321, 32'h3333_3333, 1, 0, 1'b0);
        run_frame(32'h0006_0000, 32'h0000_0470, 32'hF000_0000, 32'h4444_4444, 0, 0, 1'b0);
        // accepted frame right after a rejected one
        run_frame(32'h0007_0000, 32'h0000_0480, 32'h7000_2000, 32'h0000_9000, 0, 1, 1'b0);
        // R8: start pulse while busy
        run_frame(32'h0008_0000, 32'h0000_0490, 32'h5000_3333, 32'h0000_A000, 3, 1, 1'b1);
        run_frame(32'h0009_0000, 32'h0000_04A0, 32'h0000_0000, 32'h5555_5555, 4, 0, 1'b1);

        repeat (3) @(negedge clk);
        chk(sbq.size() == 0, "R10", "every start produced one result", sbq.size(), 32'd0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule